// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Holding FIFO

This block turns host byte writes into an asynchronous serial bit stream. The host writes characters into a small holding FIFO. The write is taken only while the FIFO has a free slot. A shifter pulls characters one at a time and frames each one. The frame is a low start bit, then 5 to 8 data bits sent least significant first, then an optional parity bit, then one high stop bit. Each bit lasts a fixed number of oversampling ticks, and a 16× baud enable pulse from outside drives those ticks. Divisor generation and interrupts are outside this block.

The host controls the block through a few control bits:
- Line control selects the character length, whether a parity bit is inserted, and the parity sense.
- A modem-control transmit enable gates the serial output.
- A loopback bit sends the serial stream to an internal receiver-side output and holds the external line high.

A status flag tells the host that at least one FIFO slot is free, so another write will be accepted.

Top module: `sertx_top`

## Requirements
- R1: After reset `txd`, `loop_rxd` and `thr_space` are all 1.
- R2: While `mc_tx_en` is 0, `txd` is 1 and no new character leaves the FIFO. A character already in flight keeps shifting internally but is not seen on `txd`.
- R3: Between characters the serial line is 1.
- R4: A frame is a start bit of 0, then the low N data bits of the written byte, least significant first. N is 5, 6, 7 or 8 for `lc_len` = 0, 1, 2 or 3.
- R5: When `lc_par_en` is 1, a parity bit follows the data. It makes the count of ones in data plus parity even when `lc_par_even` is 1, and odd when `lc_par_even` is 0. When `lc_par_en` is 0, no parity bit is sent.
- R6: The frame ends with one stop bit of 1. Every bit holds for exactly OVERSAMPLE (default 16) `baud_tick` pulses, and the line changes only on the clock edge after a tick.
- R7: A `host_wr` pulse stores `host_data` only when the FIFO holds fewer than DEPTH (default 16) characters, counted before any read in that cycle. Otherwise the write is dropped.
- R8: `thr_space` is 1 exactly when fewer than DEPTH characters are held.
- R9: A character is loaded on a tick where the shifter is idle or its stop bit is ending, the FIFO is not empty and `mc_tx_en` is 1. Queued characters therefore go out back to back with no idle gap.
- R10: While `mc_loop` is 1, `txd` is 1 and `loop_rxd` carries the serial stream. While `mc_loop` is 0, `loop_rxd` is 1.
- R11: The line-control settings are taken when a character is loaded. Changing them mid-character has no effect on that character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | Oversampling enable, one pulse per 1/16 bit |
| host_wr | input | 1 | Host write strobe |
| host_data | input | 8 | Host write data |
| lc_len | input | 2 | Character length select, 0..3 gives 5..8 bits |
| lc_par_en | input | 1 | Insert a parity bit |
| lc_par_even | input | 1 | 1 = even parity, 0 = odd parity |
| mc_tx_en | input | 1 | Transmit enable |
| mc_loop | input | 1 | Loopback mode |
| txd | output | 1 | External serial output |
| thr_space | output | 1 | At least one FIFO slot is free |
| loop_rxd | output | 1 | Serial stream routed to the receiver side in loopback |

## Verification
The hardest state to reach is a full FIFO while a write arrives in the same cycle the shifter pops an entry. Two more hard states are a stop bit ending with the next character ready, and the line-control settings changing while a character is in flight.

To reach them, the bench keeps the transmitter disabled while it writes twenty bytes. This fills the FIFO and forces drops. It then enables transmission and keeps writing so that pushes collide with pops. It also changes the length and parity mid-frame, and drops the enable while a frame is in flight. A queue-based model predicts every output on every clock.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
   localparam int unsigned CHAR_MIN  = 5;
   localparam int unsigned CHAR_MAX  = 8;
   localparam int unsigned FRAME_MAX = 1 + CHAR_MAX + 1 + 1;

   typedef struct packed {
      logic [1:0] len_sel;
      logic       par_on;
      logic       par_even;
   } line_cfg_t;

   function automatic logic [CHAR_MAX-1:0] len_mask(input logic [1:0] sel);
      case (sel)
         2'd0:    return 8'h1F;
         2'd1:    return 8'h3F;
         2'd2:    return 8'h7F;
         default: return 8'hFF;
      endcase
   endfunction
endpackage

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned DEPTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] pop_data,
   output logic             full,
   output logic             empty
);
   localparam int unsigned AW = $clog2(DEPTH);
   localparam int unsigned CW = AW + 1;

   initial begin
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("sertx_fifo: DEPTH must be a power of two, at least 2");
      assert (WIDTH >= 1) else $error("sertx_fifo: WIDTH must be positive");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr;
   logic [CW-1:0]    count_q;
   logic             wr_ok, rd_ok;

   assign full     = (count_q == CW'(DEPTH));
   assign empty    = (count_q == '0);
   assign wr_ok    = push && !full;
   assign rd_ok    = pop && !empty;
   assign pop_data = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         count_q <= '0;
      end else begin
         if (wr_ok) wr_ptr <= wr_ptr + 1'b1;
         if (rd_ok) rd_ptr <= rd_ptr + 1'b1;
         case ({wr_ok, rd_ok})
            2'b10:   count_q <= count_q + 1'b1;
            2'b01:   count_q <= count_q - 1'b1;
            default: count_q <= count_q;
         endcase
      end
   end

   // R7: a write into a full FIFO without a pop changes nothing
   p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      full && push && !pop |=> full && $stable(count_q));
   // R7: occupancy bound
   p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= CW'(DEPTH));
   // R9: no read from an empty FIFO
   p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      empty && pop && !push |=> empty);
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
   import sertx_pkg::*;
#(
   parameter int unsigned OVERSAMPLE = 16,
   parameter bit          PARITY_EN  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic                tx_en,
   input  line_cfg_t           cfg,
   input  logic                avail,
   input  logic [CHAR_MAX-1:0] data,
   output logic                load,
   output logic                line
);
   localparam int unsigned FW = FRAME_MAX;
   localparam int unsigned LW = $clog2(FW + 1);
   localparam int unsigned TW = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;

   initial begin
      assert (OVERSAMPLE >= 2 && (OVERSAMPLE & (OVERSAMPLE - 1)) == 0)
         else $error("sertx_shifter: OVERSAMPLE must be a power of two, at least 2");
   end

   logic [FW-1:0]       sh_q, frame_c;
   logic [LW-1:0]       left_q, nbits_c;
   logic [TW-1:0]       tcnt_q;
   logic                busy_q, ending, par_use, par_bit;
   logic [CHAR_MAX-1:0] dmask;

   generate
      if (PARITY_EN) begin : g_par
         assign par_use = cfg.par_on;
         assign par_bit = cfg.par_even ? ^(data & dmask) : ~^(data & dmask);
      end else begin : g_nopar
         assign par_use = 1'b0;
         assign par_bit = 1'b1;
      end
   endgenerate

   assign dmask   = len_mask(cfg.len_sel);
   assign nbits_c = LW'(2 + CHAR_MIN + 32'(cfg.len_sel) + 32'(par_use));

   always_comb begin
      logic [FW-1:0] dx;
      int unsigned   n;
      n  = CHAR_MIN + 32'(cfg.len_sel);
      dx = FW'(data);
      for (int k = 0; k < FW; k++) begin
         if (k == 0)                     frame_c[k] = 1'b0;
         else if (k <= n)                frame_c[k] = dx[k-1];
         else if (k == n + 1 && par_use) frame_c[k] = par_bit;
         else                            frame_c[k] = 1'b1;
      end
   end

   assign ending = busy_q && tick && (tcnt_q == TW'(OVERSAMPLE - 1)) && (left_q == LW'(1));
   assign load   = tick && (!busy_q || ending) && avail && tx_en;
   assign line   = sh_q[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q   <= '1;
         left_q <= '0;
         tcnt_q <= '0;
         busy_q <= 1'b0;
      end else if (load) begin
         sh_q   <= frame_c;
         left_q <= nbits_c;
         tcnt_q <= '0;
         busy_q <= 1'b1;
      end else if (busy_q && tick) begin
         if (tcnt_q == TW'(OVERSAMPLE - 1)) begin
            tcnt_q <= '0;
            sh_q   <= {1'b1, sh_q[FW-1:1]};
            left_q <= left_q - 1'b1;
            if (left_q == LW'(1)) busy_q <= 1'b0;
         end else begin
            tcnt_q <= tcnt_q + 1'b1;
         end
      end
   end

   // R3: idle line is high
   p_idle_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> line);
   // R2: nothing starts while transmit is disabled
   p_hold_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q && !tx_en |=> !busy_q);
   // R4: every frame opens with a low start bit
   p_start_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !line);
   // R6: the line moves only after a tick
   p_bit_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(line));
endmodule

// File: rtl/sertx_top.sv
module sertx_top
   import sertx_pkg::*;
#(
   parameter int unsigned DEPTH      = 16,
   parameter int unsigned OVERSAMPLE = 16,
   parameter bit          PARITY_EN  = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       baud_tick,
   input  logic       host_wr,
   input  logic [7:0] host_data,
   input  logic [1:0] lc_len,
   input  logic       lc_par_en,
   input  logic       lc_par_even,
   input  logic       mc_tx_en,
   input  logic       mc_loop,
   output logic       txd,
   output logic       thr_space,
   output logic       loop_rxd
);
   logic                fifo_full, fifo_empty, pop;
   logic [CHAR_MAX-1:0] head;
   logic                line;
   line_cfg_t           cfg;

   assign cfg = '{len_sel: lc_len, par_on: lc_par_en, par_even: lc_par_even};

   sertx_fifo #(.WIDTH(CHAR_MAX), .DEPTH(DEPTH)) i_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(host_wr), .push_data(host_data),
      .pop(pop), .pop_data(head),
      .full(fifo_full), .empty(fifo_empty)
   );

   sertx_shifter #(.OVERSAMPLE(OVERSAMPLE), .PARITY_EN(PARITY_EN)) i_shift (
      .clk(clk), .rst_n(rst_n), .tick(baud_tick), .tx_en(mc_tx_en),
      .cfg(cfg), .avail(!fifo_empty), .data(head),
      .load(pop), .line(line)
   );

   assign thr_space = !fifo_full;
   assign txd       = (mc_tx_en && !mc_loop) ? line : 1'b1;
   assign loop_rxd  = mc_loop ? line : 1'b1;

   // R10: the external line is quiet during loopback
   p_loop_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mc_loop |-> txd);
   // R8: a free slot must exist right after a pop with no write
   p_space_after_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pop && !host_wr |=> thr_space);
endmodule

// File: tb/test_sertx_top.sv
`timescale 1ns/1ps
module test_sertx_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud_tick = 1'b0;
   logic       host_wr = 1'b0;
   logic [7:0] host_data = 8'h00;
   logic [1:0] lc_len = 2'd3;
   logic       lc_par_en = 1'b0;
   logic       lc_par_even = 1'b0;
   logic       mc_tx_en = 1'b0;
   logic       mc_loop = 1'b0;
   logic       txd, thr_space, loop_rxd;

   int    checks = 0;
   int    errors = 0;
   int    tick_div = 2;
   bit    finished = 0;
   string cur_req = "R1";

   always #4 clk = ~clk;

   sertx_top i_sertx_top (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
      .host_wr(host_wr), .host_data(host_data),
      .lc_len(lc_len), .lc_par_en(lc_par_en), .lc_par_even(lc_par_even),
      .mc_tx_en(mc_tx_en), .mc_loop(mc_loop),
      .txd(txd), .thr_space(thr_space), .loop_rxd(loop_rxd)
   );

   // behavioural reference model
   int unsigned m_q[$];
   bit          m_fr[$];
   int          m_tc = 0;
   bit          m_line = 1'b1;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_q.delete(); m_fr.delete(); m_tc = 0; m_line = 1'b1;
      end else begin
         bit had, accept;
         had    = m_q.size() > 0;
         accept = m_q.size() < 16;
         if (baud_tick) begin
            if (m_fr.size() > 0) begin
               m_tc++;
               if (m_tc == 16) begin void'(m_fr.pop_front()); m_tc = 0; end
            end
            if (m_fr.size() == 0 && had && mc_tx_en) begin
               int unsigned b, n, ones;
               b = m_q.pop_front();
               n = 5 + lc_len;
               ones = 0;
               m_fr.push_back(1'b0);
               for (int i = 0; i < n; i++) begin
                  m_fr.push_back(b[i]);
                  ones += b[i];
               end
               if (lc_par_en) m_fr.push_back(lc_par_even ? ones[0] : ~ones[0]);
               m_fr.push_back(1'b1);
               m_tc = 0;
            end
         end
         if (host_wr && accept) m_q.push_back(host_data);
         m_line = (m_fr.size() > 0) ? m_fr[0] : 1'b1;
      end
   end

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         chk(cur_req, "txd", txd, (mc_tx_en && !mc_loop) ? m_line : 1'b1);
         chk(cur_req, "loop_rxd", loop_rxd, mc_loop ? m_line : 1'b1);
         chk(cur_req, "thr_space", thr_space, m_q.size() < 16);
      end
   end

   // baud tick generator
   initial begin
      int c;
      c = 0;
      forever begin
         @(posedge clk); #2;
         c++;
         if (c >= tick_div) c = 0;
         baud_tick = (c == 0);
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic put(input logic [7:0] b);
      host_wr = 1'b1; host_data = b;
      cyc(1);
      host_wr = 1'b0;
   endtask

   task automatic drain();
      int g;
      g = 0;
      while ((m_q.size() > 0 || m_fr.size() > 0) && g < 40000) begin cyc(1); g++; end
      cyc(4);
   endtask

   initial begin
      #(8 * 150000);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      cyc(3);
      // R1: reset values
      chk("R1", "txd reset", txd, 1'b1);
      chk("R1", "loop_rxd reset", loop_rxd, 1'b1);
      chk("R1", "thr_space reset", thr_space, 1'b1);
      rst_n = 1'b1;
      cyc(1);

      // R2: disabled transmitter keeps the line high and data queued
      cur_req = "R2";
      put(8'hA5); put(8'h3C); put(8'h0F);
      cyc(400);
      chk("R2", "txd disabled", txd, 1'b1);

      // R4 / R6 / R9: 8-bit frames back to back, no parity
      cur_req = "R4";
      mc_tx_en = 1'b1;
      cyc(200);
      cur_req = "R9";
      drain();
      chk("R3", "idle after drain", txd, 1'b1);

      // R5: 5-bit even parity, 6-bit odd parity, 7-bit parity off
      cur_req = "R5";
      lc_len = 2'd0; lc_par_en = 1'b1; lc_par_even = 1'b1;
      put(8'hF3); put(8'h15);
      drain();
      lc_len = 2'd1; lc_par_even = 1'b0;
      put(8'h2A); put(8'hC0);
      drain();
      lc_len = 2'd2; lc_par_en = 1'b0;
      tick_div = 3;
      put(8'h7E);
      cur_req = "R6";
      drain();
      tick_div = 2;

      // R7 / R8: overfill while disabled
      cur_req = "R7";
      mc_tx_en = 1'b0;
      lc_len = 2'd3;
      for (int i = 0; i < 20; i++) put(8'(8'h10 + i));
      chk("R8", "thr_space when full", thr_space, 1'b0);
      chk("R7", "model holds DEPTH", logic'(m_q.size() == 16), 1'b1);
      cur_req = "R9";
      mc_tx_en = 1'b1;
      // pushes colliding with pops at the full boundary
      for (int i = 0; i < 40; i++) begin
         host_wr = 1'b1; host_data = 8'(8'h80 + i);
         cyc(1);
      end
      host_wr = 1'b0;

      // R11: change line control mid-character
      cur_req = "R11";
      cyc(37);
      lc_len = 2'd0; lc_par_en = 1'b1; lc_par_even = 1'b0;
      cyc(150);
      lc_len = 2'd2; lc_par_en = 1'b0;
      drain();

      // R2: drop enable in the middle of a frame
      cur_req = "R2";
      lc_len = 2'd3;
      put(8'h96); put(8'h69);
      cyc(90);
      mc_tx_en = 1'b0;
      cyc(40);
      chk("R2", "txd after disable", txd, 1'b1);
      cyc(300);
      mc_tx_en = 1'b1;
      drain();

      // R10: loopback routes the stream internally
      cur_req = "R10";
      mc_loop = 1'b1;
      put(8'h5A); put(8'hE1);
      cyc(100);
      chk("R10", "txd in loopback", txd, 1'b1);
      drain();
      mc_loop = 1'b0;
      put(8'h33);
      cyc(80);
      chk("R10", "loop_rxd quiet", loop_rxd, 1'b1);
      drain();

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule